// File: doc/BRIEF.md
# Rotating-Priority Request Arbiter

This block picks one winner out of an N-bit request vector for switch scheduling. Priority starts at a runtime pointer and runs upward through the positions, wrapping past the top index back to position zero. The grant is a one-hot vector. A valid flag is high whenever at least one request is present. The grant path is purely combinational, from the request input and the current pointer to the grant and index outputs.

Inside the block, two fixed-priority encoders work side by side. One sees only the requests at or above the pointer. The other sees every request. A select, driven by "any request at or above the pointer", picks between their results, so the input is never shifted around a single encoder. A parameter chooses how each encoder forms its prefix terms: a serial chain, which is small, or a logarithmic tree, which is fast.

A registered pointer sits around the core. It can be loaded directly from an input. It also steps to one past the winner when the winner is accepted, which gives round-robin fairness among ports that keep requesting.

Top module: `rr_ppe_arb`

## Requirements
- R1: After reset is released, `ptr_o` is 0.
- R2: With `req_i` all zeros, `grant_o` is all zeros, `valid_o` is 0 and `grant_idx_o` is 0.
- R3: With any bit of `req_i` set, `valid_o` is 1, `grant_o` has exactly one bit set, and that bit is also set in `req_i`.
- R4: When some request at index >= `ptr_o` is set, the grant goes to the lowest such index.
- R5: When no request at index >= `ptr_o` is set, the grant goes to the lowest set index below `ptr_o` (wrap-around).
- R6: For every request vector and pointer, `grant_o` equals this result: rotate the requests so that position `ptr_o` lands at bit 0, keep only the lowest set bit, then rotate back.
- R7: `grant_idx_o` is the binary index of the set bit of `grant_o`.
- R8: When `load_i` is 1 at a clock edge, `ptr_o` takes the value of `ptr_i`, whatever `accept_i` is.
- R9: When `load_i` is 0 and `accept_i` and `valid_o` are both 1 at a clock edge, `ptr_o` becomes `grant_idx_o + 1`, and index N-1 wraps to 0.
- R10: When `load_i` is 0 and `accept_i` is 1 but `valid_o` is 0, `ptr_o` does not change.
- R11: When `load_i` and `accept_i` are both 0, `ptr_o` does not change.
- R12: The chain-style and the tree-style encoders produce the same grants for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N | Request vector, bit j is port j |
| load_i | input | 1 | Load the pointer from ptr_i at the next edge |
| ptr_i | input | $clog2(N) | Pointer value to load; must be below N |
| accept_i | input | 1 | The current grant is taken; the pointer steps past it |
| grant_o | output | N | One-hot grant (combinational) |
| valid_o | output | 1 | At least one request is present |
| grant_idx_o | output | $clog2(N) | Binary index of the granted port |
| ptr_o | output | $clog2(N) | Current priority pointer |

## Verification
The hardest cases to reach are at the wrap seam: the only request sits just below the pointer, or the pointer sits at N-1 and the winner is at index 0. In both cases the select must fall through to the unmasked encoder. Random request patterns almost never produce these cases at a chosen pointer. The stimulus therefore loads the pointer to each seam value directly and places single requests on either side of it. It also accepts a grant at index N-1, so that the pointer update itself has to wrap. A long random phase then mixes loads and accepts, and compares both encoder styles against a rotate-and-scan model.

// File: rtl/rr_ppe_pkg.sv
package rr_ppe_pkg;
  typedef enum logic {
    ENC_CHAIN = 1'b0,
    ENC_TREE  = 1'b1
  } enc_style_e;
endpackage

// File: rtl/ppe_fixed_enc.sv
// Fixed-priority encoder: the lowest set bit wins, one-hot out.
module ppe_fixed_enc
  import rr_ppe_pkg::*;
#(
  parameter int unsigned N     = 32,
  parameter enc_style_e  STYLE = ENC_TREE
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  localparam int unsigned LVL = (N > 1) ? $clog2(N) : 1;

  // clear_below[j] = no request at any index below j
  logic [N-1:0] clear_below;

  if (STYLE == ENC_CHAIN) begin : g_chain
    assign clear_below[0] = 1'b1;
    for (genvar j = 1; j < N; j++) begin : g_bit
      assign clear_below[j] = clear_below[j-1] & ~req_i[j-1];
    end
  end else begin : g_tree
    // Prefix OR, one stage per doubling of span
    logic [N-1:0] pfx [LVL+1];
    assign pfx[0] = req_i;
    for (genvar s = 0; s < LVL; s++) begin : g_lvl
      for (genvar j = 0; j < N; j++) begin : g_bit
        if (j >= (1 << s)) begin : g_or
          assign pfx[s+1][j] = pfx[s][j] | pfx[s][j-(1<<s)];
        end else begin : g_pass
          assign pfx[s+1][j] = pfx[s][j];
        end
      end
    end
    assign clear_below[0] = 1'b1;
    for (genvar j = 1; j < N; j++) begin : g_out
      assign clear_below[j] = ~pfx[LVL][j-1];
    end
  end

  assign grant_o = req_i & clear_below;
endmodule

// File: rtl/ppe_onehot_idx.sv
module ppe_onehot_idx #(
  parameter int unsigned N = 32,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] onehot_i,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int j = 0; j < N; j++) begin
      if (onehot_i[j]) idx_o = idx_o | W'(j);
    end
  end
endmodule

// File: rtl/ppe_core.sv
// Mask-and-select programmable priority encoder.
module ppe_core
  import rr_ppe_pkg::*;
#(
  parameter int unsigned N     = 32,
  parameter enc_style_e  STYLE = ENC_TREE,
  localparam int unsigned W    = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] ptr_i,
  output logic [N-1:0] grant_o,
  output logic         valid_o
);
  logic [N-1:0] hi_mask;
  logic [N-1:0] req_hi;
  logic [N-1:0] grant_hi;
  logic [N-1:0] grant_all;
  logic         use_hi;

  for (genvar j = 0; j < N; j++) begin : g_mask
    assign hi_mask[j] = (32'(ptr_i) <= j);
  end

  assign req_hi = req_i & hi_mask;
  assign use_hi = |req_hi;

  ppe_fixed_enc #(.N(N), .STYLE(STYLE)) u_enc_hi (
    .req_i   (req_hi),
    .grant_o (grant_hi)
  );

  ppe_fixed_enc #(.N(N), .STYLE(STYLE)) u_enc_all (
    .req_i   (req_i),
    .grant_o (grant_all)
  );

  assign grant_o = use_hi ? grant_hi : grant_all;
  assign valid_o = |req_i;
endmodule

// File: rtl/rr_ppe_arb.sv
module rr_ppe_arb
  import rr_ppe_pkg::*;
#(
  parameter int unsigned N     = 32,
  parameter enc_style_e  STYLE = ENC_TREE,
  localparam int unsigned W    = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         load_i,
  input  logic [W-1:0] ptr_i,
  input  logic         accept_i,
  output logic [N-1:0] grant_o,
  output logic         valid_o,
  output logic [W-1:0] grant_idx_o,
  output logic [W-1:0] ptr_o
);
  logic [W-1:0] ptr_q, ptr_d;
  logic [W-1:0] step_ptr;

  ppe_core #(.N(N), .STYLE(STYLE)) u_core (
    .req_i   (req_i),
    .ptr_i   (ptr_q),
    .grant_o (grant_o),
    .valid_o (valid_o)
  );

  ppe_onehot_idx #(.N(N)) u_idx (
    .onehot_i (grant_o),
    .idx_o    (grant_idx_o)
  );

  assign step_ptr = (grant_idx_o == W'(N-1)) ? '0 : grant_idx_o + W'(1);

  always_comb begin
    ptr_d = ptr_q;
    if (load_i)                   ptr_d = ptr_i;
    else if (accept_i && valid_o) ptr_d = step_ptr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/rr_ppe_arb_chk.sv
module rr_ppe_arb_chk #(
  parameter int unsigned N = 32,
  localparam int unsigned W = $clog2(N)
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] req_i,
  input logic         load_i,
  input logic [W-1:0] ptr_i,
  input logic         accept_i,
  input logic [N-1:0] grant_o,
  input logic         valid_o,
  input logic [W-1:0] grant_idx_o,
  input logic [W-1:0] ptr_o
);
  AST_IDLE_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |-> (grant_o == '0 && !valid_o)); // R2

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> ($countones(grant_o) == 1 && valid_o)); // R3

  AST_GRANT_IN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~req_i) == '0); // R3

  AST_GRANT_ABOVE_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i >> ptr_o) != '0) |-> (grant_idx_o >= ptr_o)); // R4

  AST_GRANT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ((req_i >> ptr_o) == '0)) |-> (grant_idx_o < ptr_o)); // R5

  AST_IDX_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> grant_o[grant_idx_o]); // R7

  AST_PTR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ptr_o == $past(ptr_i))); // R8

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && accept_i && valid_o) |=>
      (ptr_o == (($past(grant_idx_o) == W'(N-1)) ? W'(0) : $past(grant_idx_o) + W'(1)))); // R9

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(accept_i && valid_o)) |=> $stable(ptr_o)); // R10 R11
endmodule

bind rr_ppe_arb rr_ppe_arb_chk #(.N(N)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .load_i      (load_i),
  .ptr_i       (ptr_i),
  .accept_i    (accept_i),
  .grant_o     (grant_o),
  .valid_o     (valid_o),
  .grant_idx_o (grant_idx_o),
  .ptr_o       (ptr_o)
);

// File: tb/rr_ppe_arb_bench.sv
`timescale 1ns/100ps
module rr_ppe_arb_bench;
  import rr_ppe_pkg::*;
  localparam int unsigned N = 32;
  localparam int unsigned W = $clog2(N);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         load = 1'b0;
  logic [W-1:0] ptr_in = '0;
  logic         accept = 1'b0;
  logic [N-1:0] grant_t, grant_c;
  logic         valid_t, valid_c;
  logic [W-1:0] idx_t, idx_c, ptr_t, ptr_c;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rr_ppe_arb #(.N(N), .STYLE(ENC_TREE)) u_rr_ppe_arb (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .load_i(load), .ptr_i(ptr_in),
    .accept_i(accept), .grant_o(grant_t), .valid_o(valid_t),
    .grant_idx_o(idx_t), .ptr_o(ptr_t));

  rr_ppe_arb #(.N(N), .STYLE(ENC_CHAIN)) u_rr_ppe_arb_chain (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .load_i(load), .ptr_i(ptr_in),
    .accept_i(accept), .grant_o(grant_c), .valid_o(valid_c),
    .grant_idx_o(idx_c), .ptr_o(ptr_c));

  typedef struct {
    logic [N-1:0] grant;
    logic         valid;
    logic [W-1:0] idx;
    logic [W-1:0] ptr;
    string        tag;
  } exp_t;

  exp_t         sb_q[$];
  logic [W-1:0] model_ptr = '0;

  // Scan upward from p with wrap; the first set request wins.
  function automatic exp_t model(input logic [N-1:0] r, input logic [W-1:0] p, input string tag);
    exp_t e;
    e.grant = '0; e.valid = 1'b0; e.idx = '0; e.ptr = p; e.tag = tag;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(p) + k) % N;
      if (!e.valid && r[j]) begin
        e.valid = 1'b1;
        e.grant[j] = 1'b1;
        e.idx = W'(j);
      end
    end
    return e;
  endfunction

  task automatic drive(input logic [N-1:0] r, input logic ld, input logic [W-1:0] pv,
                       input logic acc, input string tag);
    exp_t e;
    @(negedge clk);
    req = r; load = ld; ptr_in = pv; accept = acc;
    e = model(r, model_ptr, tag);
    sb_q.push_back(e);
    if (ld)                model_ptr = pv;
    else if (acc && e.valid) model_ptr = (e.idx == W'(N-1)) ? '0 : e.idx + W'(1);
  endtask

  task automatic cmp(input string tag, input string what, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        cmp(e.tag, "grant", grant_t, e.grant);
        cmp(e.tag, "valid", N'(valid_t), N'(e.valid));
        cmp(e.tag, "idx", N'(idx_t), N'(e.idx));
        cmp(e.tag, "ptr", N'(ptr_t), N'(e.ptr));
        cmp({e.tag, " R12"}, "chain_grant", grant_c, grant_t);
        cmp({e.tag, " R12"}, "chain_ptr", N'(ptr_c), N'(ptr_t));
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R2: after reset, no requests
    drive('0, 1'b0, '0, 1'b0, "R1 R2");
    drive('0, 1'b0, '0, 1'b1, "R10");          // accept with no request
    drive(N'(1) << 7, 1'b0, '0, 1'b0, "R3");    // pointer still 0
    drive(N'(1) << 7, 1'b0, '0, 1'b0, "R11");   // no accept, pointer held
    // R4: pointer 5, requests at 2 and 9 -> 9
    drive('0, 1'b1, W'(5), 1'b0, "R8");
    drive((N'(1) << 2) | (N'(1) << 9), 1'b0, '0, 1'b0, "R4");
    drive((N'(1) << 5) | (N'(1) << 9), 1'b0, '0, 1'b0, "R4 at_ptr");
    // R5: pointer 20, requests at 3 and 7 -> 3
    drive('0, 1'b1, W'(20), 1'b0, "R8");
    drive((N'(1) << 3) | (N'(1) << 7), 1'b0, '0, 1'b0, "R5");
    drive(N'(1) << 19, 1'b0, '0, 1'b0, "R5 just_below");
    // Top seam
    drive('0, 1'b1, W'(N-1), 1'b0, "R8");
    drive(N'(1), 1'b0, '0, 1'b0, "R5 seam");
    drive(N'(1) << (N-1), 1'b0, '0, 1'b1, "R9 wrap");  // idx N-1 accepted -> ptr 0
    drive(N'(1) << (N-1), 1'b0, '0, 1'b0, "R9 after_wrap");
    // Load beats accept
    drive({N{1'b1}}, 1'b1, W'(17), 1'b1, "R8 over_accept");
    drive({N{1'b1}}, 1'b0, '0, 1'b1, "R9 all_req");
    drive({N{1'b1}}, 1'b0, '0, 1'b1, "R9 step");
    drive('0, 1'b0, '0, 1'b1, "R2 R10");
    // Rotation over a fixed pair of requests
    for (int i = 0; i < 8; i++)
      drive((N'(1) << 4) | (N'(1) << 25), 1'b0, '0, 1'b1, "R9 rotate");
    // R6: random sweep
    for (int i = 0; i < 600; i++) begin
      logic [N-1:0] r;
      r = N'($urandom) & N'($urandom);
      if (i % 7 == 0) r = N'(1) << ($urandom % N);
      if (i % 11 == 0) r = '0;
      drive(r, ($urandom % 5) == 0, W'($urandom % N), ($urandom % 2) == 0, "R6");
    end
    drive('0, 1'b0, '0, 1'b0, "R2");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule